// File: doc/BRIEF.md
# Command-Sequence Write Guard

This block sits in front of an 8K-byte nonvolatile array split into two 4K planes and decides, for each byte written to the array, whether the write may go ahead. It watches the stream of write requests (address and data) and recognises two keyed command sequences. The short one unlocks the current page load for data writes. The long one opens an 8-bit lock mask in which each bit guards one 1K region. The key offsets are compared within a plane: the top address bit picks the plane and is not part of the comparison.

Every data write gets exactly one verdict, permit or deny, in the cycle after the request. Command bytes that match the expected key get no verdict. Consecutive writes of a sequence or a page load must come no more than `WINDOW` cycles apart. If that spacing is exceeded, the recogniser falls back to idle, and the next data write needs a fresh unlock. The lock mask comes out of reset with a parameterised value that stands in for retained contents. It is always visible on a debug output.

Top module: `cmd_write_guard`

## Requirements
- R1: After reset, permit_o and deny_o are low and lock_mask_o equals the parameter MASK_RESET.
- R2: The key bytes 0xAA to offset 0x555, then 0x55 to offset 0xAAA, then 0xA0 to offset 0x555 unlock the page. The next data write to an unprotected block gives permit_o high for one cycle in the cycle after the request.
- R3: Key offsets are matched on address bits 11:0 only. Bit 12 of the first key byte selects the plane, and every later key byte of the same sequence must carry the same bit 12, or it counts as a mismatch.
- R4: A data write with no preceding unlock gives deny_o high in the cycle after the request.
- R5: A write that is not the expected next key byte gives deny_o and returns the recogniser to idle, so a following data write is also denied.
- R6: After an unlock, further data writes are judged while each arrives at most WINDOW cycles after the previous write. A write that arrives later is treated as a new page load and is denied without a new unlock.
- R7: The bytes 0xAA@0x555, 0x55@0xAAA, 0xC0@0x555, 0xAA@0x555, 0x55@0xAAA open the lock mask. The next write, to any address, loads its data byte into lock_mask_o in the cycle after the request. None of these six writes gets a verdict.
- R8: Mask bit i covers addresses i*0x400 to i*0x400+0x3FF (block index = address bits 12:10). A 1 makes data writes there denied even after a valid unlock, and the page stays unlocked for the other blocks.
- R9: A key byte that arrives more than WINDOW cycles after the previous key byte does not continue the sequence.
- R10: permit_o and deny_o are never high together, are high only in the cycle right after a write request, and stay low for key bytes that match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_valid_i | input | 1 | One write request this cycle |
| wr_addr_i | input | ADDR_W (13) | Byte address of the write; bit 12 selects the plane |
| wr_data_i | input | DATA_W (8) | Data byte of the write |
| permit_o | output | 1 | Previous cycle's data write is allowed |
| deny_o | output | 1 | Previous cycle's data write is refused |
| lock_mask_o | output | NUM_BLOCKS (8) | Current per-block lock mask (debug) |

## Verification
A request driven at a falling edge is captured at the next rising edge. Its verdict and any mask load appear at the falling edge after that, one register stage later, and the bench samples exactly there for every write. Window expiry is due on the WINDOW-th write-free rising edge after the last write. So the bench spaces writes by gaps of WINDOW-1 idle cycles (still inside the window) and WINDOW idle cycles (expired), and checks the following verdict. A sweep loads a series of computed masks and writes once to every block under each, comparing each verdict with the mask bit for that block.

// File: rtl/wpu_pkg.sv
package wpu_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GOT1,
    ST_GOT2,
    ST_OPEN,
    ST_LK3,
    ST_LK4,
    ST_LOAD
  } seq_state_e;

  localparam logic [7:0]  KEY_FIRST   = 8'hAA;
  localparam logic [7:0]  KEY_SECOND  = 8'h55;
  localparam logic [7:0]  KEY_UNLOCK  = 8'hA0;
  localparam logic [7:0]  KEY_LOCKREG = 8'hC0;
  localparam logic [11:0] OFS_LO      = 12'h555;
  localparam logic [11:0] OFS_HI      = 12'hAAA;

endpackage

// File: rtl/wpu_load_window.sv
module wpu_load_window #(
  parameter int WINDOW = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_valid_i,
  input  logic active_i,
  output logic expired_o
);
  localparam int CNT_W = $clog2(WINDOW + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WINDOW - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = wr_valid_i | active_i;

  always_comb begin
    cnt_d = cnt_q;
    if (wr_valid_i)          cnt_d = '0;
    else if (cnt_q != LAST)  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired_o = active_i & ~wr_valid_i & (cnt_q == LAST);

  // R9: the count never passes the last idle slot while a sequence is live
  a_r9_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_i |-> (cnt_q <= LAST));

endmodule

// File: rtl/wpu_lock_mask.sv
module wpu_lock_mask #(
  parameter int                    ADDR_W     = 13,
  parameter int                    NUM_BLOCKS = 8,
  parameter logic [NUM_BLOCKS-1:0] MASK_RESET = '0
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  load_i,
  input  logic [NUM_BLOCKS-1:0] data_i,
  input  logic [ADDR_W-1:0]     addr_i,
  output logic                  locked_o,
  output logic [NUM_BLOCKS-1:0] mask_o
);
  localparam int BLK_W = $clog2(NUM_BLOCKS);

  logic [NUM_BLOCKS-1:0] mask_q;
  logic [BLK_W-1:0]      blk_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     mask_q <= MASK_RESET;
    else if (load_i) mask_q <= data_i;
  end

  assign blk_idx  = addr_i[ADDR_W-1 -: BLK_W];
  assign locked_o = mask_q[blk_idx];
  assign mask_o   = mask_q;

  // R7: the mask changes only on the edge that takes a load
  a_r7_mask_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(load_i) |-> $stable(mask_q));

endmodule

// File: rtl/wpu_seq_fsm.sv
module wpu_seq_fsm
  import wpu_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              expired_i,
  input  logic              blk_locked_i,
  output logic              load_o,
  output logic              active_o,
  output logic              permit_o,
  output logic              deny_o
);
  localparam int OFS_W = ADDR_W - 1;
  localparam int PL    = ADDR_W - 1;

  seq_state_e state_q, state_d;
  logic       plane_q, plane_d;
  logic       permit_q, permit_d, deny_q, deny_d;
  logic       at_lo, at_hi, same_pl;
  logic [7:0] byte_in;

  assign byte_in = wr_data_i[7:0];
  assign at_lo   = wr_addr_i[OFS_W-1:0] == OFS_W'(OFS_LO);
  assign at_hi   = wr_addr_i[OFS_W-1:0] == OFS_W'(OFS_HI);
  assign same_pl = wr_addr_i[PL] == plane_q;

  always_comb begin
    state_d  = state_q;
    plane_d  = plane_q;
    permit_d = 1'b0;
    deny_d   = 1'b0;
    load_o   = 1'b0;
    if (wr_valid_i) begin
      unique case (state_q)
        ST_IDLE: begin
          if (at_lo && byte_in == KEY_FIRST) begin
            state_d = ST_GOT1;
            plane_d = wr_addr_i[PL];
          end else deny_d = 1'b1;
        end
        ST_GOT1: begin
          if (same_pl && at_hi && byte_in == KEY_SECOND) state_d = ST_GOT2;
          else begin state_d = ST_IDLE; deny_d = 1'b1; end
        end
        ST_GOT2: begin
          if (same_pl && at_lo && byte_in == KEY_UNLOCK)       state_d = ST_OPEN;
          else if (same_pl && at_lo && byte_in == KEY_LOCKREG) state_d = ST_LK3;
          else begin state_d = ST_IDLE; deny_d = 1'b1; end
        end
        ST_OPEN: begin
          permit_d = ~blk_locked_i;
          deny_d   = blk_locked_i;
        end
        ST_LK3: begin
          if (same_pl && at_lo && byte_in == KEY_FIRST) state_d = ST_LK4;
          else begin state_d = ST_IDLE; deny_d = 1'b1; end
        end
        ST_LK4: begin
          if (same_pl && at_hi && byte_in == KEY_SECOND) state_d = ST_LOAD;
          else begin state_d = ST_IDLE; deny_d = 1'b1; end
        end
        ST_LOAD: begin
          load_o  = 1'b1;
          state_d = ST_IDLE;
        end
        default: state_d = ST_IDLE;
      endcase
    end else if (expired_i) begin
      state_d = ST_IDLE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      plane_q  <= 1'b0;
      permit_q <= 1'b0;
      deny_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      plane_q  <= plane_d;
      permit_q <= permit_d;
      deny_q   <= deny_d;
    end
  end

  assign active_o = state_q != ST_IDLE;
  assign permit_o = permit_q;
  assign deny_o   = deny_q;

  // R9: an expired window always drops the recogniser to idle
  a_r9_expiry_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expired_i |=> state_q == ST_IDLE);

  // R6: an open page stays open while writes keep arriving in time
  a_r6_open_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_OPEN && !expired_i) |=> state_q == ST_OPEN);

  // R2: a permit is only ever issued from the unlocked state
  a_r2_permit_from_open: assert property (@(posedge clk_i) disable iff (!rst_ni)
    permit_q |-> $past(state_q) == ST_OPEN);

endmodule

// File: rtl/cmd_write_guard.sv
module cmd_write_guard #(
  parameter int                    ADDR_W     = 13,
  parameter int                    DATA_W     = 8,
  parameter int                    NUM_BLOCKS = 8,
  parameter int                    WINDOW     = 16,
  parameter logic [NUM_BLOCKS-1:0] MASK_RESET = '0
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_valid_i,
  input  logic [ADDR_W-1:0]     wr_addr_i,
  input  logic [DATA_W-1:0]     wr_data_i,
  output logic                  permit_o,
  output logic                  deny_o,
  output logic [NUM_BLOCKS-1:0] lock_mask_o
);
  logic rst_meta_q, rst_sync_n;
  logic expired, active, mask_load, blk_locked;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  wpu_load_window #(.WINDOW(WINDOW)) i_window (
    .clk_i      (clk_i),
    .rst_ni     (rst_sync_n),
    .wr_valid_i (wr_valid_i),
    .active_i   (active),
    .expired_o  (expired)
  );

  wpu_lock_mask #(
    .ADDR_W     (ADDR_W),
    .NUM_BLOCKS (NUM_BLOCKS),
    .MASK_RESET (MASK_RESET)
  ) i_mask (
    .clk_i    (clk_i),
    .rst_ni   (rst_sync_n),
    .load_i   (mask_load),
    .data_i   (wr_data_i[NUM_BLOCKS-1:0]),
    .addr_i   (wr_addr_i),
    .locked_o (blk_locked),
    .mask_o   (lock_mask_o)
  );

  wpu_seq_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_sync_n),
    .wr_valid_i   (wr_valid_i),
    .wr_addr_i    (wr_addr_i),
    .wr_data_i    (wr_data_i),
    .expired_i    (expired),
    .blk_locked_i (blk_locked),
    .load_o       (mask_load),
    .active_o     (active),
    .permit_o     (permit_o),
    .deny_o       (deny_o)
  );

  // R10: one verdict at most
  a_r10_exclusive: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    !(permit_o && deny_o));

  // R10: a verdict follows a request by exactly one cycle
  a_r10_after_request: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (permit_o || deny_o) |-> $past(wr_valid_i));

  // R8: a locked block never sees a permit
  a_r8_locked_no_permit: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    permit_o |-> !$past(blk_locked));

endmodule

// File: tb/test_cmd_write_guard.sv
module test_cmd_write_guard;
  localparam int         WIN   = 6;
  localparam logic [7:0] MRST  = 8'h80;
  localparam int         NONE  = 0;
  localparam int         PERM  = 1;
  localparam int         DENY  = 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_valid;
  logic [12:0] wr_addr;
  logic [7:0]  wr_data;
  logic        permit, deny;
  logic [7:0]  mask;
  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  cmd_write_guard #(
    .ADDR_W(13), .DATA_W(8), .NUM_BLOCKS(8), .WINDOW(WIN), .MASK_RESET(MRST)
  ) i_cmd_write_guard (
    .clk_i(clk), .rst_ni(rst_n), .wr_valid_i(wr_valid), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .permit_o(permit), .deny_o(deny), .lock_mask_o(mask)
  );

  task automatic expect_dec(input string req, input int exp);
    int got;
    got = (permit && deny) ? 3 : permit ? PERM : deny ? DENY : NONE;
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: verdict %0d expected %0d (0 none,1 permit,2 deny)", req, got, exp);
    end
  endtask

  task automatic expect_mask(input string req, input logic [7:0] exp);
    tests++;
    if (mask !== exp) begin
      fails++;
      $display("FAIL %s: mask %h expected %h", req, mask, exp);
    end
  endtask

  task automatic wr(input logic [12:0] a, input logic [7:0] d, input int exp, input string req);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
    expect_dec(req, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic unlock(input logic pl, input string req);
    wr({pl, 12'h555}, 8'hAA, NONE, req);
    wr({pl, 12'hAAA}, 8'h55, NONE, req);
    wr({pl, 12'h555}, 8'hA0, NONE, req);
  endtask

  task automatic load_mask(input logic pl, input logic [7:0] m, input string req);
    wr({pl, 12'h555}, 8'hAA, NONE, req);
    wr({pl, 12'hAAA}, 8'h55, NONE, req);
    wr({pl, 12'h555}, 8'hC0, NONE, req);
    wr({pl, 12'h555}, 8'hAA, NONE, req);
    wr({pl, 12'hAAA}, 8'h55, NONE, req);
    wr(13'h1234, m, NONE, req);
    expect_mask(req, m);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, got hang expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_valid = 1'b0; wr_addr = '0; wr_data = '0;
    idle(3);
    rst_n = 1'b1;
    idle(4);
    // R1 reset state
    expect_dec("R1", NONE);
    expect_mask("R1", MRST);

    // R4 no unlock
    wr(13'h0100, 8'h12, DENY, "R4");
    // R2 unlock then permit
    unlock(1'b0, "R2");
    wr(13'h0200, 8'h34, PERM, "R2");
    // R10 verdict gone one cycle later
    idle(1);
    expect_dec("R10", NONE);
    // R6 gap of WIN-1 idle cycles (total spacing WIN) still in page
    idle(WIN - 2);
    wr(13'h0201, 8'h35, PERM, "R6");
    idle(WIN);
    wr(13'h0202, 8'h36, DENY, "R6");
    idle(WIN);

    // R8 reset mask protects block 7; plane 1 unlock (R3)
    unlock(1'b1, "R3");
    wr(13'h1C00, 8'h01, DENY, "R8");
    wr(13'h1BFF, 8'h02, PERM, "R8");
    wr(13'h0000, 8'h03, PERM, "R3");
    idle(WIN);

    // R3 mixed plane key bytes
    wr(13'h0555, 8'hAA, NONE, "R3");
    wr(13'h1AAA, 8'h55, DENY, "R3");
    wr(13'h0300, 8'h00, DENY, "R3");

    // R5 wrong key byte
    wr(13'h0555, 8'hAA, NONE, "R5");
    wr(13'h0AAA, 8'h12, DENY, "R5");
    wr(13'h0AAA, 8'h55, DENY, "R5");
    wr(13'h0555, 8'hA0, DENY, "R5");
    wr(13'h0400, 8'h77, DENY, "R5");

    // R9 key byte too late
    wr(13'h0555, 8'hAA, NONE, "R9");
    idle(WIN);
    wr(13'h0AAA, 8'h55, DENY, "R9");
    wr(13'h0555, 8'hA0, DENY, "R9");
    // R9 key byte at the edge of the window still counts
    wr(13'h0555, 8'hAA, NONE, "R9");
    idle(WIN - 1);
    wr(13'h0AAA, 8'h55, NONE, "R9");
    wr(13'h0555, 8'hA0, NONE, "R9");
    wr(13'h0800, 8'h09, PERM, "R9");
    idle(WIN);

    // R7 / R8 sweep of masks over all blocks
    for (int k = 0; k < 8; k++) begin
      logic [7:0] m;
      m = 8'((k * 8'h35) ^ 8'hA9);
      load_mask(k[0], m, "R7");
      unlock(k[1], "R7");
      for (int b = 0; b < 8; b++) begin
        wr(13'((b * 1024) + (b * 7) + k), 8'(b), m[b] ? DENY : PERM, "R8");
      end
      idle(WIN);
      expect_mask("R7", m);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule